// File: doc/BRIEF.md
# Separated Response Join Tracker

This block sits beside a coherent requester that issues reads whose data and completion response come back as two independent messages, on two separate channels. Each outstanding read occupies one entry, selected by its transaction ID. The tracker records which of the two parts has arrived. It holds the data word and its attribute fields as soon as they arrive, even when the response is still missing. It reports a result to the requester pipeline only when both parts are present.

When the second part arrives, the tracker compares the two parts. Both carry a 2-bit coherence-state field and a 2-bit error field. A clean match produces a commit carrying the transaction ID and the held data word. Any disagreement, a non-zero error field, or a repeated part produces an error result instead. A result stays on the output channel until the pipeline accepts it with a ready handshake, and the entry is then free again. A request to an entry that is already busy raises a one-cycle protocol flag. A part arriving for an entry with nothing outstanding raises a one-cycle unexpected flag.

Top module: `sepJoinTracker`

## Requirements
- R1: A transaction completes with a commit whether its data part arrives before its response part or after it.
- R2: While only one of the two parts of an open transaction has arrived, `outValid` is never asserted for that transaction.
- R3: When the second part arrives in cycle N (or both parts arrive together in cycle N), the result is valid on the output in cycle N+1.
- R4: The result is an error (`outIsErr`=1) instead of a commit when the two coherence-state fields differ, when the two error fields differ, or when either error field is non-zero. A commit presents the data word held for that ID on `outWord`.
- R5: A second data part or a second response part for an entry whose join has not finished makes that entry's result an error.
- R6: A request whose ID names an entry that is not free pulses `protoErr` high for one cycle, in the next cycle. It leaves that entry's progress unchanged.
- R7: A data or response part for an entry that has no open join (free, or holding a finished result) pulses `unexpected` high for one cycle, in the next cycle. The part is not stored, so a later transaction on that ID still waits for its own data part.
- R8: While `outValid` is high and `outReady` is low, `outValid`, `outId`, `outIsErr` and `outWord` hold steady. The handshake frees the entry, so a new request on that ID is accepted without `protoErr`.
- R9: When no result is being held, the finished entry with the lowest ID is presented first.
- R10: After reset, every entry is free and `outValid`, `protoErr` and `unexpected` are low.
- R11: The gap between the two parts changes only the cycle of the result, not its kind or its data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A new read is opened on entry `reqId` |
| reqId | input | IDW | Transaction ID of the new read |
| datValid | input | 1 | Data part present this cycle |
| datId | input | IDW | Transaction ID of the data part |
| datWord | input | DW | Data word of the data part |
| datState | input | 2 | Coherence-state field carried with the data |
| datErr | input | 2 | Error field carried with the data |
| rspValid | input | 1 | Response part present this cycle |
| rspId | input | IDW | Transaction ID of the response part |
| rspState | input | 2 | Coherence-state field of the response |
| rspErr | input | 2 | Error field of the response |
| outValid | output | 1 | A commit or error result is offered |
| outReady | input | 1 | The pipeline accepts the offered result |
| outId | output | IDW | Transaction ID of the offered result |
| outWord | output | DW | Held data word (meaningful for a commit) |
| outIsErr | output | 1 | 1 = error result, 0 = commit |
| protoErr | output | 1 | One-cycle flag: request on a busy entry |
| unexpected | output | 1 | One-cycle flag: part with no open join |

## Verification
A part that completes a join on clock edge N shows up as a valid result right after that edge, so the bench reads the output channel in the low phase of the clock that follows. The two flags are registered and also appear in that same phase, and a handshake frees its entry on the edge where `outReady` is sampled high. The bench drives inputs on falling edges and compares every output on the next falling edge, one full edge after the stimulus. The expected values come from a per-entry reference model that moves through the same arrival cases. Directed sequences cover both arrival orders, simultaneous arrival, a long gap, mismatches, duplicates, busy requests, stray parts and priority under a held result, and a seeded random phase runs with random ready back-pressure.

// File: rtl/sepJoinPkg.sv
package sepJoinPkg;

  // Life cycle of one tracker entry.
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT     = 3'd1,
    ST_HAVE_DAT = 3'd2,
    ST_HAVE_RSP = 3'd3,
    ST_DONE_OK  = 3'd4,
    ST_DONE_ERR = 3'd5
  } entState_t;

  // Strobes from the control to the datapath for one entry.
  typedef struct packed {
    logic capDat;
    logic capRsp;
  } entStrobe_t;

endpackage

// File: rtl/sepJoinData.sv
module sepJoinData
  import sepJoinPkg::*;
#(
  parameter int IDW = 3,
  parameter int DW  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  entStrobe_t [(1<<IDW)-1:0] strb,
  input  logic                   datValid,
  input  logic [IDW-1:0]         datId,
  input  logic [DW-1:0]          datWord,
  input  logic [1:0]             datState,
  input  logic [1:0]             datErr,
  input  logic                   rspValid,
  input  logic [IDW-1:0]         rspId,
  input  logic [1:0]             rspState,
  input  logic [1:0]             rspErr,
  input  logic [IDW-1:0]         outSel,
  input  logic                   outCommit,
  output logic [(1<<IDW)-1:0]    fit,
  output logic [DW-1:0]          outWord
);
  localparam int N = 1 << IDW;

  logic [DW-1:0] wordQ [N];
  logic [1:0]    dStQ  [N];
  logic [1:0]    dErQ  [N];
  logic [1:0]    rStQ  [N];
  logic [1:0]    rErQ  [N];

  // Speculative hold of each part's fields until the join resolves.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        wordQ[i] <= '0;
        dStQ[i]  <= '0;
        dErQ[i]  <= '0;
        rStQ[i]  <= '0;
        rErQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (strb[i].capDat) begin
          wordQ[i] <= datWord;
          dStQ[i]  <= datState;
          dErQ[i]  <= datErr;
        end
        if (strb[i].capRsp) begin
          rStQ[i] <= rspState;
          rErQ[i] <= rspErr;
        end
      end
    end
  end

  // Consistency of the two parts, taking a part from the channel when it
  // arrives this cycle and from the hold registers otherwise.
  for (genvar g = 0; g < N; g++) begin : gFit
    logic       useDat, useRsp;
    logic [1:0] dSt, dEr, rSt, rEr;
    assign useDat = datValid && (datId == IDW'(g));
    assign useRsp = rspValid && (rspId == IDW'(g));
    assign dSt    = useDat ? datState : dStQ[g];
    assign dEr    = useDat ? datErr   : dErQ[g];
    assign rSt    = useRsp ? rspState : rStQ[g];
    assign rEr    = useRsp ? rspErr   : rErQ[g];
    assign fit[g] = (dSt == rSt) && (dEr == rEr) && (dEr == 2'b00) && (rEr == 2'b00);
  end

  assign outWord = wordQ[outSel];

  // R4: a commit leaves only with matching, error-free held fields.
  assert_commit_consistent_R4: assert property (@(posedge clk) disable iff (!rstN)
    outCommit |-> (dStQ[outSel] == rStQ[outSel]) && (dErQ[outSel] == 2'b00)
                  && (rErQ[outSel] == 2'b00));

endmodule

// File: rtl/sepJoinCtrl.sv
module sepJoinCtrl
  import sepJoinPkg::*;
#(
  parameter int IDW = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [IDW-1:0]         reqId,
  input  logic                   datValid,
  input  logic [IDW-1:0]         datId,
  input  logic                   rspValid,
  input  logic [IDW-1:0]         rspId,
  input  logic [(1<<IDW)-1:0]    fit,
  input  logic                   outReady,
  output entStrobe_t [(1<<IDW)-1:0] strb,
  output logic                   outValid,
  output logic [IDW-1:0]         outSel,
  output logic                   outIsErr,
  output logic                   protoErr,
  output logic                   unexpected
);
  localparam int N = 1 << IDW;

  entState_t      st    [N];
  entState_t      stNxt [N];
  logic [N-1:0]   hitReq, hitDat, hitRsp, ackV, doneVec, badReq, badMsg;
  logic           holdQ;
  logic [IDW-1:0] holdSelQ, firstDone;
  logic           anyDone;

  for (genvar g = 0; g < N; g++) begin : gEnt
    assign hitReq[g]  = reqValid && (reqId == IDW'(g));
    assign hitDat[g]  = datValid && (datId == IDW'(g));
    assign hitRsp[g]  = rspValid && (rspId == IDW'(g));
    assign ackV[g]    = outValid && outReady && (outSel == IDW'(g));
    assign doneVec[g] = (st[g] == ST_DONE_OK) || (st[g] == ST_DONE_ERR);

    // R2: a free entry can never jump straight to a commit.
    assert_no_early_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
      (st[g] == ST_IDLE) |=> (st[g] != ST_DONE_OK));
  end

  // Fixed priority: lowest finished ID wins when nothing is held.
  always_comb begin
    firstDone = '0;
    anyDone   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (doneVec[i]) begin
        firstDone = IDW'(i);
        anyDone   = 1'b1;
      end
    end
  end

  assign outValid = holdQ | anyDone;
  assign outSel   = holdQ ? holdSelQ : firstDone;
  assign outIsErr = (st[outSel] == ST_DONE_ERR);

  // Per-entry join state machine.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      stNxt[i]  = st[i];
      strb[i]   = '0;
      badReq[i] = hitReq[i] && (st[i] != ST_IDLE);
      badMsg[i] = (hitDat[i] || hitRsp[i]) && ((st[i] == ST_IDLE) || doneVec[i]);
      case (st[i])
        ST_IDLE: begin
          if (hitReq[i]) stNxt[i] = ST_WAIT;
        end
        ST_WAIT: begin
          strb[i].capDat = hitDat[i];
          strb[i].capRsp = hitRsp[i];
          if (hitDat[i] && hitRsp[i]) stNxt[i] = fit[i] ? ST_DONE_OK : ST_DONE_ERR;
          else if (hitDat[i])         stNxt[i] = ST_HAVE_DAT;
          else if (hitRsp[i])         stNxt[i] = ST_HAVE_RSP;
        end
        ST_HAVE_DAT: begin
          strb[i].capRsp = hitRsp[i] && !hitDat[i];
          if (hitDat[i])      stNxt[i] = ST_DONE_ERR;
          else if (hitRsp[i]) stNxt[i] = fit[i] ? ST_DONE_OK : ST_DONE_ERR;
        end
        ST_HAVE_RSP: begin
          strb[i].capDat = hitDat[i] && !hitRsp[i];
          if (hitRsp[i])      stNxt[i] = ST_DONE_ERR;
          else if (hitDat[i]) stNxt[i] = fit[i] ? ST_DONE_OK : ST_DONE_ERR;
        end
        default: begin
          if (ackV[i]) stNxt[i] = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) st[i] <= ST_IDLE;
      holdQ      <= 1'b0;
      holdSelQ   <= '0;
      protoErr   <= 1'b0;
      unexpected <= 1'b0;
    end else begin
      for (int i = 0; i < N; i++) st[i] <= stNxt[i];
      holdQ      <= outValid && !outReady;
      holdSelQ   <= outSel;
      protoErr   <= |badReq;
      unexpected <= |badMsg;
    end
  end

  // R8: an offered result does not move until it is taken.
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outSel) && $stable(outIsErr)));

  // R6: a request on a busy entry is flagged one cycle later.
  assert_busy_request_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (st[reqId] != ST_IDLE)) |=> protoErr);

  // R7: a data part with no open join is flagged one cycle later.
  assert_stray_data_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (datValid && (st[datId] == ST_IDLE)) |=> unexpected);

  // R9: without a held result, nothing finished sits below the offered ID.
  assert_lowest_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !holdQ) |-> ((doneVec & ((N'(1) << outSel) - N'(1))) == '0));

endmodule

// File: rtl/sepJoinTracker.sv
module sepJoinTracker
  import sepJoinPkg::*;
#(
  parameter int IDW = 3,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  input  logic [IDW-1:0] reqId,
  input  logic           datValid,
  input  logic [IDW-1:0] datId,
  input  logic [DW-1:0]  datWord,
  input  logic [1:0]     datState,
  input  logic [1:0]     datErr,
  input  logic           rspValid,
  input  logic [IDW-1:0] rspId,
  input  logic [1:0]     rspState,
  input  logic [1:0]     rspErr,
  output logic           outValid,
  input  logic           outReady,
  output logic [IDW-1:0] outId,
  output logic [DW-1:0]  outWord,
  output logic           outIsErr,
  output logic           protoErr,
  output logic           unexpected
);
  localparam int N = 1 << IDW;

  entStrobe_t [N-1:0] strb;
  logic [N-1:0]       fit;
  logic [IDW-1:0]     outSel;

  sepJoinCtrl #(.IDW(IDW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqId      (reqId),
    .datValid   (datValid),
    .datId      (datId),
    .rspValid   (rspValid),
    .rspId      (rspId),
    .fit        (fit),
    .outReady   (outReady),
    .strb       (strb),
    .outValid   (outValid),
    .outSel     (outSel),
    .outIsErr   (outIsErr),
    .protoErr   (protoErr),
    .unexpected (unexpected)
  );

  sepJoinData #(.IDW(IDW), .DW(DW)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .datValid  (datValid),
    .datId     (datId),
    .datWord   (datWord),
    .datState  (datState),
    .datErr    (datErr),
    .rspValid  (rspValid),
    .rspId     (rspId),
    .rspState  (rspState),
    .rspErr    (rspErr),
    .outSel    (outSel),
    .outCommit (outValid && !outIsErr),
    .fit       (fit),
    .outWord   (outWord)
  );

  assign outId = outSel;

endmodule

// File: tb/sepJoinTracker_tb.sv
`timescale 1ns/1ps
module sepJoinTracker_tb;
  localparam int IDW = 3;
  localparam int DW  = 16;
  localparam int N   = 1 << IDW;

  logic clk = 1'b0;
  logic rstN;
  logic reqValid, datValid, rspValid, outReady;
  logic [IDW-1:0] reqId, datId, rspId;
  logic [DW-1:0]  datWord;
  logic [1:0]     datState, datErr, rspState, rspErr;
  logic           outValid, outIsErr, protoErr, unexpected;
  logic [IDW-1:0] outId;
  logic [DW-1:0]  outWord;

  always #2.5 clk = ~clk;

  sepJoinTracker #(.IDW(IDW), .DW(DW)) u_dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqId(reqId),
    .datValid(datValid), .datId(datId), .datWord(datWord),
    .datState(datState), .datErr(datErr),
    .rspValid(rspValid), .rspId(rspId), .rspState(rspState), .rspErr(rspErr),
    .outValid(outValid), .outReady(outReady), .outId(outId),
    .outWord(outWord), .outIsErr(outIsErr),
    .protoErr(protoErr), .unexpected(unexpected)
  );

  int nChecks = 0;
  int nErrs   = 0;
  bit finished = 0;

  // Reference model: 0 free, 1 waiting both, 2 data held, 3 response held,
  // 4 commit ready, 5 error ready.
  int         mSt [N];
  logic [DW-1:0] mWord [N];
  logic [1:0] mDS [N], mDE [N], mRS [N], mRE [N];
  bit         mHold;
  int         mHoldSel;
  bit         eProto, eUnexp;
  logic [1:0] intS [N], intE [N];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit fitOf(int i, bit hD, bit hS);
    logic [1:0] ds, de, rs, re;
    ds = hD ? datState : mDS[i];
    de = hD ? datErr   : mDE[i];
    rs = hS ? rspState : mRS[i];
    re = hS ? rspErr   : mRE[i];
    return (ds == rs) && (de == re) && (de == 2'b00);
  endfunction

  task automatic clearIn();
    reqValid = 0; datValid = 0; rspValid = 0;
    reqId = '0; datId = '0; rspId = '0; datWord = '0;
    datState = '0; datErr = '0; rspState = '0; rspErr = '0;
  endtask

  // Compare outputs at this falling edge, apply the inputs set by the caller
  // to the model, and advance to the next falling edge.
  task automatic step(string tag);
    bit gv, ge;
    int gs;
    int pre [N];
    gv = 0; gs = 0;
    if (mHold) begin gv = 1; gs = mHoldSel; end
    else for (int i = N - 1; i >= 0; i--) if (mSt[i] >= 4) begin gv = 1; gs = i; end
    ge = (mSt[gs] == 5);
    chk({tag, " R8 outValid"}, 32'(outValid), 32'(gv));
    if (gv) begin
      chk({tag, " R9 outId"}, 32'(outId), 32'(gs));
      chk({tag, " R4 outIsErr"}, 32'(outIsErr), 32'(ge));
      if (!ge) chk({tag, " R4 outWord"}, 32'(outWord), 32'(mWord[gs]));
    end
    chk({tag, " R6 protoErr"}, 32'(protoErr), 32'(eProto));
    chk({tag, " R7 unexpected"}, 32'(unexpected), 32'(eUnexp));

    pre = mSt;
    eProto = reqValid && (pre[reqId] != 0);
    eUnexp = (datValid && (pre[datId] == 0 || pre[datId] >= 4)) ||
             (rspValid && (pre[rspId] == 0 || pre[rspId] >= 4));
    for (int i = 0; i < N; i++) begin
      bit hR, hD, hS;
      hR = reqValid && (reqId == IDW'(i));
      hD = datValid && (datId == IDW'(i));
      hS = rspValid && (rspId == IDW'(i));
      case (pre[i])
        0: if (hR) mSt[i] = 1;
        1: begin
          if (hD && hS) mSt[i] = fitOf(i, 1, 1) ? 4 : 5;
          else if (hD) mSt[i] = 2;
          else if (hS) mSt[i] = 3;
          if (hD) begin mWord[i] = datWord; mDS[i] = datState; mDE[i] = datErr; end
          if (hS) begin mRS[i] = rspState; mRE[i] = rspErr; end
        end
        2: begin
          if (hD) mSt[i] = 5;
          else if (hS) begin
            mSt[i] = fitOf(i, 0, 1) ? 4 : 5;
            mRS[i] = rspState; mRE[i] = rspErr;
          end
        end
        3: begin
          if (hS) mSt[i] = 5;
          else if (hD) begin
            mSt[i] = fitOf(i, 1, 0) ? 4 : 5;
            mWord[i] = datWord; mDS[i] = datState; mDE[i] = datErr;
          end
        end
        default: ;
      endcase
    end
    if (gv && outReady) mSt[gs] = 0;
    mHold    = gv && !outReady;
    mHoldSel = gs;
    @(negedge clk);
    clearIn();
  endtask

  task automatic doReq(int id, string tag);
    reqValid = 1; reqId = IDW'(id); step(tag);
  endtask
  task automatic doDat(int id, logic [DW-1:0] w, logic [1:0] s, logic [1:0] e, string tag);
    datValid = 1; datId = IDW'(id); datWord = w; datState = s; datErr = e; step(tag);
  endtask
  task automatic doRsp(int id, logic [1:0] s, logic [1:0] e, string tag);
    rspValid = 1; rspId = IDW'(id); rspState = s; rspErr = e; step(tag);
  endtask
  task automatic ack(string tag);
    outReady = 1; step(tag); outReady = 0;
  endtask

  function automatic int pickId(int lo, int hi);
    int cand [$];
    for (int i = 0; i < N; i++) if (mSt[i] == lo || mSt[i] == hi) cand.push_back(i);
    if (cand.size() == 0 || ($urandom % 4) == 0) return int'($urandom % N);
    return cand[$urandom % cand.size()];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nErrs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin
      mSt[i] = 0; mWord[i] = '0; mDS[i] = '0; mDE[i] = '0; mRS[i] = '0; mRE[i] = '0;
      intS[i] = '0; intE[i] = '0;
    end
    mHold = 0; mHoldSel = 0; eProto = 0; eUnexp = 0;
    clearIn();
    outReady = 0;
    rstN = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R10: reset state
    chk("R10 outValid", 32'(outValid), 0);
    chk("R10 protoErr", 32'(protoErr), 0);
    chk("R10 unexpected", 32'(unexpected), 0);

    // R1: data first, then response after a gap (R11)
    doReq(2, "R1");
    doDat(2, 16'hAAAA, 2'd1, 2'd0, "R1");
    chk("R2 data only", 32'(outValid), 0);
    repeat (3) step("R11");
    chk("R2 still waiting", 32'(outValid), 0);
    doRsp(2, 2'd1, 2'd0, "R1");
    chk("R3 commit after response", 32'(outValid), 1);
    chk("R1 commit word", 32'(outWord), 32'hAAAA);
    repeat (2) step("R8");
    chk("R8 held", 32'(outId), 2);
    ack("R8");
    doReq(2, "R8 reuse");
    chk("R8 no protoErr on freed ID", 32'(protoErr), 0);
    doDat(2, 16'h1111, 2'd2, 2'd0, "R1");
    doRsp(2, 2'd2, 2'd0, "R1");
    ack("R1");

    // R1: response first, then data
    doReq(5, "R1");
    doRsp(5, 2'd3, 2'd0, "R1");
    chk("R2 response only", 32'(outValid), 0);
    doDat(5, 16'h5A5A, 2'd3, 2'd0, "R1");
    chk("R1 reverse commit", 32'(outIsErr), 0);
    chk("R1 reverse word", 32'(outWord), 32'h5A5A);
    ack("R1");

    // R3: both parts in the same cycle
    doReq(3, "R3");
    datValid = 1; datId = 3; datWord = 16'hC0DE; datState = 2'd2; datErr = 2'd0;
    rspValid = 1; rspId = 3; rspState = 2'd2; rspErr = 2'd0;
    step("R3");
    chk("R3 same-cycle commit", 32'(outValid), 1);
    chk("R3 id", 32'(outId), 3);
    ack("R3");

    // R4: state mismatch, then equal but non-zero error fields
    doReq(1, "R4");
    doDat(1, 16'h0101, 2'd1, 2'd0, "R4");
    doRsp(1, 2'd2, 2'd0, "R4");
    chk("R4 state mismatch", 32'(outIsErr), 1);
    ack("R4");
    doReq(1, "R4");
    doRsp(1, 2'd1, 2'd2, "R4");
    doDat(1, 16'h0202, 2'd1, 2'd2, "R4");
    chk("R4 error field", 32'(outIsErr), 1);
    ack("R4");

    // R5: duplicate data part
    doReq(4, "R5");
    doDat(4, 16'h4444, 2'd0, 2'd0, "R5");
    doDat(4, 16'h4445, 2'd0, 2'd0, "R5");
    chk("R5 duplicate data", 32'(outIsErr), 1);
    ack("R5");
    doReq(4, "R5");
    doRsp(4, 2'd0, 2'd0, "R5");
    doRsp(4, 2'd0, 2'd0, "R5");
    chk("R5 duplicate response", 32'(outIsErr), 1);
    ack("R5");

    // R6: request on a busy entry
    doReq(6, "R6");
    doReq(6, "R6");
    chk("R6 busy flag", 32'(protoErr), 1);
    step("R6");
    chk("R6 flag one cycle", 32'(protoErr), 0);
    doDat(6, 16'h6666, 2'd1, 2'd0, "R6");
    doRsp(6, 2'd1, 2'd0, "R6");
    chk("R6 entry unaffected", 32'(outIsErr), 0);
    ack("R6");

    // R7: stray data part is flagged and not stored
    doDat(7, 16'hDEAD, 2'd1, 2'd0, "R7");
    chk("R7 stray flag", 32'(unexpected), 1);
    doReq(7, "R7");
    doRsp(7, 2'd1, 2'd0, "R7");
    chk("R7 nothing stored", 32'(outValid), 0);
    doDat(7, 16'hBEEF, 2'd1, 2'd0, "R7");
    chk("R7 fresh word", 32'(outWord), 32'hBEEF);
    ack("R7");

    // R9: held result, then lowest finished ID first
    doReq(6, "R9"); doReq(5, "R9"); doReq(2, "R9");
    doDat(6, 16'h0606, 2'd0, 2'd0, "R9");
    doRsp(6, 2'd0, 2'd0, "R9");
    doDat(5, 16'h0505, 2'd0, 2'd0, "R9");
    doRsp(5, 2'd0, 2'd0, "R9");
    doDat(2, 16'h0202, 2'd0, 2'd0, "R9");
    doRsp(2, 2'd0, 2'd0, "R9");
    chk("R8 held under newer results", 32'(outId), 6);
    ack("R9");
    chk("R9 lowest first", 32'(outId), 2);
    ack("R9");
    chk("R9 next", 32'(outId), 5);
    ack("R9");

    // R11: seeded random traffic with random back-pressure
    for (int c = 0; c < 4000; c++) begin
      if (($urandom % 4) == 0) begin
        int id;
        id = int'($urandom % N);
        reqValid = 1; reqId = IDW'(id);
        if (mSt[id] == 0) begin
          intS[id] = 2'($urandom);
          intE[id] = (($urandom % 10) == 0) ? 2'd1 : 2'd0;
        end
      end
      if (($urandom % 3) == 0) begin
        int id;
        id = pickId(1, 3);
        datValid = 1; datId = IDW'(id); datWord = DW'($urandom);
        datState = intS[id] ^ ((($urandom % 10) == 0) ? 2'd1 : 2'd0);
        datErr = intE[id];
      end
      if (($urandom % 3) == 0) begin
        int id;
        id = pickId(1, 2);
        rspValid = 1; rspId = IDW'(id); rspState = intS[id]; rspErr = intE[id];
      end
      outReady = (($urandom % 3) != 0);
      step("R11");
    end
    outReady = 1;
    repeat (12) step("R11 drain");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end
endmodule